// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterized number of peripheral sources, 128 by default. Every source owns a sticky request flag, an enable bit and a three-bit priority. Among all flagged and enabled sources, the block picks the one with the highest priority. When two sources share the same priority, the lower vector number wins. The block then compares the winner's priority with the CPU's current four-bit priority level. If the winner's priority is strictly above that level, it raises a request. With the request it presents the vector number, the winner's priority and the fetch address of the vector.

A small word-wide register bus lets software read and write the state. Through it software clears flags, sets enables and priorities, and writes the control bits (nesting disable and alternate vector table). It can also read or adjust the CPU level.

The CPU signals acceptance of a request with a one-cycle acknowledge. On an acknowledge the block saves the current level on an internal stack. It then raises the level to the accepted priority, or to 7 when nesting is disabled. A return pulse restores the saved level. The top bit of the level is driven by a trap-active input and cannot be written by software.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_set[n]` sets flag n at the next clock edge, and the flag stays set until software clears it. Flag n reads back as bit n%16 of the word at address n/16.
- R2: Writing the flag word at address n/16 with bit n%16 at 1 clears flag n at that edge. If a set pulse for the same source arrives in the same cycle as the clear, the flag stays set.
- R3: Enable n is bit n%16 of the word at address 8 + n/16. A source whose flag is set but whose enable is 0 never wins arbitration, and its flag is kept.
- R4: Priority n is held in bits [4*(n%4)+2 : 4*(n%4)] of the word at address 16 + n/4, and the other bits of that word read as 0. Among the flagged and enabled sources, the highest priority wins.
- R5: Among flagged and enabled sources of equal priority, the lowest vector number wins.
- R6: `irq_req` is 1 only when the winner's priority is strictly greater than the CPU level. As a result, a source with priority 0 never raises a request.
- R7: The CPU level reads at address 49. Bits [2:0] are software-writable. Bit 3 always equals `trap_active` and ignores writes. While `trap_active` is 1, no request is raised.
- R8: The control word sits at address 48 (bit 0 = nesting disable, bit 1 = alternate table). With nesting enabled, `irq_ack` sets the level to the accepted `irq_prio` and saves the old level. Each `irq_ret` restores the most recently saved level.
- R9: With nesting disabled, `irq_ack` sets the level bits [2:0] to 7.
- R10: `irq_addr` equals 0x14 + 2*`irq_vec`, plus 0x100 when the alternate-table bit is set.
- R11: `irq_req`, `irq_vec` and `irq_prio` are registered. They reflect a flag set at clock edge k, or a level or enable change written at edge k, after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | NUM_SRC | Per-source request pulses |
| trap_active | input | 1 | Drives bit 3 of the CPU level |
| bus_addr | input | 6 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_ret | input | 1 | CPU returns from an interrupt |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 7 | Winning vector number |
| irq_prio | output | 3 | Winning priority |
| irq_addr | output | 24 | Vector fetch address |

## Verification
A set pulse lands in the flag register at the first edge and reaches the registered request, vector and priority at the second. The bench therefore drives a pulse for one cycle and samples one nanosecond after the following edge. Bus writes and acknowledge or return pulses update their registers at the edge that samples them. Level, flag and control readback is combinational, so it is checked right after that edge. Request changes caused by a level write are checked one edge later. `irq_addr` follows the alternate-table bit in the same cycle, so it is checked immediately after the control write.

// File: rtl/prio_irq_pkg.sv
// Package: shared widths and vector-table constants for the interrupt controller.
// Assumes a 24-bit program address space and 16-bit register words.
package prio_irq_pkg;
    localparam int DATA_W    = 16;
    localparam int PRIO_W    = 3;
    localparam int LVL_W     = PRIO_W + 1;
    localparam int IADDR_W   = 24;
    localparam logic [IADDR_W-1:0] TBL_BASE = 24'h000014;
    localparam logic [IADDR_W-1:0] ALT_OFS  = 24'h000100;
endpackage

// File: rtl/irq_regfile.sv
// Register file: sticky flags, enables, priorities and control bits behind a
// simple word bus. Assumes NUM_SRC is a multiple of 16. Address map:
// flags at 0.., enables after them, four priorities per word next, then
// control and CPU level words.
module irq_regfile
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int ADDR_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_set,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [LVL_W-1:0]     level,
    output logic                 lvl_wr,
    output logic [PRIO_W-1:0]    lvl_wdata,
    output logic [NUM_SRC-1:0]   active,
    output logic [PRIO_W-1:0]    prio [NUM_SRC],
    output logic                 nest_dis,
    output logic                 alt_tbl
);
    localparam int NUM_FW   = NUM_SRC / DATA_W;
    localparam int NUM_PW   = NUM_SRC / 4;
    localparam int EN_BASE  = NUM_FW;
    localparam int PR_BASE  = 2 * NUM_FW;
    localparam int CTL_ADDR = PR_BASE + NUM_PW;
    localparam int LVL_ADDR = CTL_ADDR + 1;

    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] clr_mask;

    // Decode software clear masks per flag word.
    genvar w;
    generate
        for (w = 0; w < NUM_FW; w++) begin : g_word
            assign clr_mask[DATA_W*w +: DATA_W] =
                (bus_wr && bus_addr == ADDR_W'(w)) ? bus_wdata : '0;

            // Enable word register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    en_q[DATA_W*w +: DATA_W] <= '0;
                else if (bus_wr && bus_addr == ADDR_W'(EN_BASE + w))
                    en_q[DATA_W*w +: DATA_W] <= bus_wdata;
            end
        end
    endgenerate

    // Sticky flags: clear by write-one, a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | src_set;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ($past(flag_q) & ~$past(clr_mask)))
                  == ($past(flag_q) & ~$past(clr_mask)))); // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(src_set)) == $past(src_set))); // R2

    // Per-source priority field register.
    genvar n;
    generate
        for (n = 0; n < NUM_SRC; n++) begin : g_prio
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio[n] <= '0;
                else if (bus_wr && bus_addr == ADDR_W'(PR_BASE + n / 4))
                    prio[n] <= bus_wdata[4*(n%4) +: PRIO_W];
            end
        end
    endgenerate

    // Control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nest_dis <= 1'b0;
            alt_tbl  <= 1'b0;
        end else if (bus_wr && bus_addr == ADDR_W'(CTL_ADDR)) begin
            nest_dis <= bus_wdata[0];
            alt_tbl  <= bus_wdata[1];
        end
    end

    assign active    = flag_q & en_q;
    assign lvl_wr    = bus_wr && bus_addr == ADDR_W'(LVL_ADDR);
    assign lvl_wdata = bus_wdata[PRIO_W-1:0];

    // Read multiplexer over all register words.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_FW; i++) begin
            if (bus_addr == ADDR_W'(i))           bus_rdata = flag_q[DATA_W*i +: DATA_W];
            if (bus_addr == ADDR_W'(EN_BASE + i)) bus_rdata = en_q[DATA_W*i +: DATA_W];
        end
        for (int i = 0; i < NUM_PW; i++) begin
            if (bus_addr == ADDR_W'(PR_BASE + i))
                for (int k = 0; k < 4; k++)
                    bus_rdata[4*k +: PRIO_W] = prio[4*i+k];
        end
        if (bus_addr == ADDR_W'(CTL_ADDR)) bus_rdata[1:0] = {alt_tbl, nest_dis};
        if (bus_addr == ADDR_W'(LVL_ADDR)) bus_rdata[LVL_W-1:0] = level;
    end
endmodule

// File: rtl/irq_arbiter.sv
// Arbiter: picks the highest-priority active source, lowest vector on ties,
// and registers the winner plus a request gated by the CPU level.
// Assumes the level input already carries the trap bit on top.
module irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int VEC_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  active,
    input  logic [PRIO_W-1:0]   prio [NUM_SRC],
    input  logic [LVL_W-1:0]    level,
    output logic                req_q,
    output logic [VEC_W-1:0]    vec_q,
    output logic [PRIO_W-1:0]   prio_q
);
    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [VEC_W-1:0]  best_v;

    // Scan from the top so an equal priority at a lower vector replaces.
    always_comb begin
        found  = 1'b0;
        best_p = '0;
        best_v = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (active[n] && (!found || prio[n] >= best_p)) begin
                found  = 1'b1;
                best_p = prio[n];
                best_v = VEC_W'(n);
            end
        end
    end

    // Register the winner and the level-gated request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            vec_q  <= '0;
            prio_q <= '0;
        end else begin
            req_q  <= found && ({1'b0, best_p} > level);
            vec_q  <= best_v;
            prio_q <= best_p;
        end
    end

    AST_PRIO0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (prio_q != '0)); // R6
endmodule

// File: rtl/irq_level.sv
// CPU priority level: software-writable low bits, trap input on top, a save
// stack pushed on acknowledge and popped on return. Acknowledge takes
// precedence over return, which takes precedence over a software write.
module irq_level
    import prio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_active,
    input  logic               ack,
    input  logic               ret,
    input  logic [PRIO_W-1:0]  ack_prio,
    input  logic               nest_dis,
    input  logic               sw_wr,
    input  logic [PRIO_W-1:0]  sw_data,
    output logic [LVL_W-1:0]   level
);
    localparam int DEPTH = 2 ** PRIO_W;
    localparam int SP_W  = PRIO_W + 1;

    logic [PRIO_W-1:0] ipl_q;
    logic [PRIO_W-1:0] stk [DEPTH];
    logic [SP_W-1:0]   sp_q;
    logic [SP_W-1:0]   sp_m1;

    assign sp_m1 = sp_q - 1'b1;
    assign level = {trap_active, ipl_q};

    // Level register and save stack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipl_q <= '0;
            sp_q  <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (ack) begin
            ipl_q <= nest_dis ? {PRIO_W{1'b1}} : ack_prio;
            if (sp_q < SP_W'(DEPTH)) begin
                stk[sp_q[PRIO_W-1:0]] <= ipl_q;
                sp_q <= sp_q + 1'b1;
            end
        end else if (ret) begin
            if (sp_q != '0) begin
                ipl_q <= stk[sp_m1[PRIO_W-1:0]];
                sp_q  <= sp_m1;
            end
        end else if (sw_wr) begin
            ipl_q <= sw_data;
        end
    end

    AST_ACK_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !nest_dis) |=> (ipl_q == $past(ack_prio))); // R8
    AST_ACK_NONEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && nest_dis) |=> (ipl_q == {PRIO_W{1'b1}})); // R9
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: prioritized vectored interrupt controller. Connects the register
// file, arbiter and level tracker, and forms the vector fetch address from
// the registered vector and the table-select bit.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 128,
    localparam int VEC_W  = $clog2(NUM_SRC),
    localparam int ADDR_W = $clog2(3 * NUM_SRC / DATA_W + NUM_SRC / 4 + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_set,
    input  logic                trap_active,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                irq_ack,
    input  logic                irq_ret,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vec,
    output logic [PRIO_W-1:0]   irq_prio,
    output logic [IADDR_W-1:0]  irq_addr
);
    logic [NUM_SRC-1:0] active;
    logic [PRIO_W-1:0]  prio [NUM_SRC];
    logic [LVL_W-1:0]   level;
    logic               lvl_wr;
    logic [PRIO_W-1:0]  lvl_wdata;
    logic               nest_dis;
    logic               alt_tbl;

    irq_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_set(src_set),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .level(level), .lvl_wr(lvl_wr),
        .lvl_wdata(lvl_wdata), .active(active), .prio(prio),
        .nest_dis(nest_dis), .alt_tbl(alt_tbl)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .active(active), .prio(prio),
        .level(level), .req_q(irq_req), .vec_q(irq_vec), .prio_q(irq_prio)
    );

    irq_level u_lvl (
        .clk(clk), .rst_n(rst_n), .trap_active(trap_active),
        .ack(irq_ack), .ret(irq_ret), .ack_prio(irq_prio),
        .nest_dis(nest_dis), .sw_wr(lvl_wr), .sw_data(lvl_wdata),
        .level(level)
    );

    // Vector fetch address from the selected table.
    assign irq_addr = TBL_BASE + IADDR_W'({irq_vec, 1'b0})
                    + (alt_tbl ? ALT_OFS : '0);

    AST_TRAP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        trap_active |=> !irq_req); // R7
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int NS = 128;
    localparam int NROW = 8;
    // Vector table: sources a/b with priorities, CPU level, expected winner and request.
    localparam int TA [NROW] = '{5, 20, 100, 40, 0, 17, 33, 126};
    localparam int TPA[NROW] = '{3, 4, 7, 2, 1, 0, 5, 1};
    localparam int TB [NROW] = '{9, 3, 127, 41, 64, 18, 34, 1};
    localparam int TPB[NROW] = '{6, 4, 7, 2, 1, 0, 6, 3};
    localparam int TL [NROW] = '{0, 0, 2, 2, 0, 0, 5, 3};
    localparam int TV [NROW] = '{9, 3, 100, 40, 0, 17, 34, 1};
    localparam int TR [NROW] = '{1, 1, 1, 0, 1, 0, 1, 0};

    logic clk = 0, rst_n = 0, trap_active = 0, bus_wr = 0, irq_ack = 0, irq_ret = 0;
    logic [NS-1:0] src_set = '0;
    logic [5:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic irq_req;
    logic [6:0] irq_vec;
    logic [2:0] irq_prio;
    logic [23:0] irq_addr;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl uut (.*);

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(int a, int d);
        bus_addr = 6'(a); bus_wdata = 16'(d); bus_wr = 1; cyc(); bus_wr = 0;
    endtask

    task automatic rd(int a, output int d);
        bus_addr = 6'(a); #0.5; d = int'(bus_rdata);
    endtask

    task automatic do_reset();
        rst_n = 0; src_set = '0; trap_active = 0; irq_ack = 0; irq_ret = 0;
        cyc(); cyc(); rst_n = 1;
    endtask

    task automatic pulse(int s);
        src_set[s] = 1; cyc(); src_set = '0;
    endtask

    task automatic ack(); irq_ack = 1; cyc(); irq_ack = 0; endtask
    task automatic ret(); irq_ret = 1; cyc(); irq_ret = 0; endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int d;
        // Table walk: R4 R5 R6 R10 R11
        for (int r = 0; r < NROW; r++) begin
            do_reset();
            if (TA[r] / 16 == TB[r] / 16)
                wr(8 + TA[r] / 16, (1 << (TA[r] % 16)) | (1 << (TB[r] % 16)));
            else begin
                wr(8 + TA[r] / 16, 1 << (TA[r] % 16));
                wr(8 + TB[r] / 16, 1 << (TB[r] % 16));
            end
            if (TA[r] / 4 == TB[r] / 4)
                wr(16 + TA[r] / 4, (TPA[r] << (4 * (TA[r] % 4))) | (TPB[r] << (4 * (TB[r] % 4))));
            else begin
                wr(16 + TA[r] / 4, TPA[r] << (4 * (TA[r] % 4)));
                wr(16 + TB[r] / 4, TPB[r] << (4 * (TB[r] % 4)));
            end
            wr(49, TL[r]);
            src_set[TA[r]] = 1; src_set[TB[r]] = 1; cyc(); src_set = '0;
            cyc();
            check($sformatf("R4/R5 row %0d vec", r), int'(irq_vec), TV[r]);
            check($sformatf("R6/R11 row %0d req", r), int'(irq_req), TR[r]);
            check($sformatf("R10 row %0d addr", r), int'(irq_addr), 'h14 + 2 * TV[r]);
        end

        // Reset state: R1 R7 R8
        do_reset();
        check("R6 reset req", int'(irq_req), 0);
        rd(0, d); check("R1 reset flags", d, 0);
        rd(49, d); check("R7 reset level", d, 0);
        rd(48, d); check("R8 reset ctrl", d, 0);

        // Sticky flag with enable off: R1 R3
        wr(21, 5 << 4);
        rd(21, d); check("R4 prio field readback", d, 5 << 4);
        pulse(21); cyc();
        check("R3 disabled no req", int'(irq_req), 0);
        rd(1, d); check("R1 flag sticky", d, 1 << 5);
        wr(9, 1 << 5); cyc();
        check("R3 enabled req", int'(irq_req), 1);
        check("R3 enabled vec", int'(irq_vec), 21);

        // Write-one clear, then same-cycle set wins: R2
        wr(1, 1 << 5);
        rd(1, d); check("R2 clear", d, 0);
        src_set[21] = 1; bus_addr = 6'd1; bus_wdata = 16'(1 << 5); bus_wr = 1;
        cyc(); bus_wr = 0; src_set = '0;
        rd(1, d); check("R2 set wins", d, 1 << 5);

        // Alternate table: R10
        wr(48, 2);
        check("R10 alt addr", int'(irq_addr), 'h13E);
        wr(48, 0);
        check("R10 primary addr", int'(irq_addr), 'h3E);

        // Nesting: R8 R6
        ack();
        rd(49, d); check("R8 level after ack", d, 5);
        cyc();
        check("R6 no req at equal level", int'(irq_req), 0);
        wr(38, 7 << 8); wr(13, 1 << 10);
        pulse(90); cyc();
        check("R8 nested req", int'(irq_req), 1);
        check("R8 nested vec", int'(irq_vec), 90);
        ack();
        rd(49, d); check("R8 nested level", d, 7);
        ret();
        rd(49, d); check("R8 first restore", d, 5);
        ret();
        rd(49, d); check("R8 second restore", d, 0);

        // Nesting disabled: R9
        wr(48, 1); wr(5, 1 << 10); cyc();
        check("R9 req vec", int'(irq_vec), 21);
        check("R9 req", int'(irq_req), 1);
        ack();
        rd(49, d); check("R9 forced level", d, 7);
        ret();
        rd(49, d); check("R9 restore", d, 0);

        // Trap bit: R7
        cyc(); cyc();
        check("R7 req before trap", int'(irq_req), 1);
        trap_active = 1; cyc(); cyc();
        check("R7 trap masks", int'(irq_req), 0);
        rd(49, d); check("R7 trap bit read", d, 8);
        wr(49, 15);
        rd(49, d); check("R7 write low bits", d, 15);
        trap_active = 0;
        rd(49, d); check("R7 top bit not stored", d, 7);

        // Priority zero alone: R6
        do_reset();
        wr(8, 1 << 2); pulse(2); cyc();
        check("R6 prio0 no req", int'(irq_req), 0);
        check("R6 prio0 vec", int'(irq_vec), 2);

        summary();
    end
endmodule